// File: doc/BRIEF.md
# Correlation-Based Integer and Fractional Delay Estimator

This block measures how far a complex baseband feedback stream lags behind the complex reference stream it came from. A single start pulse arms one capture window. The block stores the reference samples of that window and the longer run of feedback samples it needs. It then forms the complex cross-correlation at every candidate lag from 0 to L-1, and the lag with the largest squared magnitude becomes the integer delay.

The peak is then refined by fitting a parabola through the peak value and its two neighbouring lags. This gives an offset in steps of 1/64 sample. A one-cycle done pulse marks the moment the three results are valid. They stay on the outputs until the next run completes. The block feeds the alignment stage of a linearisation observation path, where the integer part is applied as a sample delay and the fraction drives a separate interpolator.

Top module: `xcorr_delay_est`

## Requirements
- R1: While reset is active and after it is released, `done`, `lag_out`, `frac_out` and `edge_out` are all zero.
- R2: Once a start pulse is accepted, the block stores the first N reference samples marked by `ref_valid` and the first N+L-1 feedback samples marked by `fb_valid`. Samples offered before the start pulse, and samples offered after a stream's count is reached, have no effect on the results.
- R3: For each lag k in 0..L-1 the block forms C(k) = sum over n in 0..N-1 of fb[n+k]·conj(ref[n]), with metric Re(C)²+Im(C)². `lag_out` is the lag with the largest metric.
- R4: When several lags share the largest metric, the smallest of those lags is reported.
- R5: For an interior peak with metric c, left neighbour m and right neighbour p, `frac_out` is a 7-bit two's complement value. It equals 64·(m−p)/(2·(m−2c+p)), truncated toward zero and clipped to the range −32..+31. It is zero when the denominator is zero.
- R6: When the peak lies at lag 0 or at lag L-1, `frac_out` is zero and `edge_out` is 1. For an interior peak, `edge_out` is 0.
- R7: `done` is high for exactly one cycle per run. It rises L·(N+1)+10 cycles after the last stored sample for an interior peak, and L·(N+1)+3 cycles after it for an edge peak. The results hold their values between done pulses.
- R8: A start pulse that arrives while a run is in progress is ignored. The run finishes with its own result and no second done pulse follows.
- R9: Full-scale inputs at both extremes give the exact correlation result, with no accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms one capture window when idle |
| ref_valid | input | 1 | Reference sample strobe |
| ref_i | input | W | Reference in-phase sample, signed |
| ref_q | input | W | Reference quadrature sample, signed |
| fb_valid | input | 1 | Feedback sample strobe |
| fb_i | input | W | Feedback in-phase sample, signed |
| fb_q | input | W | Feedback quadrature sample, signed |
| lag_out | output | clog2(L) | Integer lag of the correlation peak |
| frac_out | output | 7 | Fractional offset in 1/64 sample, signed |
| edge_out | output | 1 | Peak at the first or last lag |
| done | output | 1 | One-cycle result strobe |

## Verification
The latency of the results is fixed by the mode. An interior peak reaches the outputs L·(N+1)+10 cycles after the last sample that completes capture. An edge peak gets there seven cycles sooner, because it skips the divider. The bench counts falling edges from that last capture cycle until `done` is seen. It compares the count with the figure due for the expected peak position, and reads `lag_out`, `frac_out` and `edge_out` on that same falling edge. One cycle later it checks that `done` has dropped and the results have held. After a start pulse injected mid-run, it watches a further window to confirm that no extra done pulse appears.

// File: rtl/xcorr_delay_est.sv
module xcorr_delay_est #(
  parameter int W = 8,
  parameter int N = 32,
  parameter int L = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   ref_valid,
  input  logic signed [W-1:0]    ref_i,
  input  logic signed [W-1:0]    ref_q,
  input  logic                   fb_valid,
  input  logic signed [W-1:0]    fb_i,
  input  logic signed [W-1:0]    fb_q,
  output logic [$clog2(L)-1:0]   lag_out,
  output logic signed [6:0]      frac_out,
  output logic                   edge_out,
  output logic                   done
);
  localparam int NF  = N + L - 1;
  localparam int NCW = $clog2(N + 1);
  localparam int FCW = $clog2(NF + 1);
  localparam int NAW = $clog2(N);
  localparam int FAW = $clog2(NF);
  localparam int LW  = $clog2(L);
  localparam int PW  = 2 * W + 1;
  localparam int AW  = 2 * W + $clog2(N) + 1;
  localparam int MW  = 2 * AW;
  localparam int DW  = MW + 3;
  localparam int RW  = MW + 10;

  typedef enum logic [2:0] {S_IDLE, S_CAP, S_MAC, S_MAG, S_PICK, S_DIV, S_FIN} st_t;
  st_t st;

  logic signed [W-1:0] rim [N];
  logic signed [W-1:0] rqm [N];
  logic signed [W-1:0] fim [NF];
  logic signed [W-1:0] fqm [NF];
  logic [MW-1:0]       mag_m [L];

  logic [NCW-1:0] rcnt;
  logic [FCW-1:0] fcnt;
  logic [NAW-1:0] n;
  logic [LW-1:0]  k, bidx;
  logic signed [AW-1:0] acc_re, acc_im;
  logic [MW-1:0]  best;
  logic [RW-1:0]  rem, den_r;
  logic [2:0]     qb;
  logic [6:0]     q;
  logic           neg, eflag;

  wire ref_take = (st == S_CAP) && ref_valid && (rcnt < NCW'(N));
  wire fb_take  = (st == S_CAP) && fb_valid && (fcnt < FCW'(NF));
  wire cap_full = (rcnt == NCW'(N)) && (fcnt == FCW'(NF));

  wire [FAW-1:0] fa = FAW'(k) + FAW'(n);
  wire signed [W-1:0] ai = fim[fa];
  wire signed [W-1:0] aq = fqm[fa];
  wire signed [W-1:0] bi = rim[n];
  wire signed [W-1:0] bq = rqm[n];
  wire signed [PW-1:0] p_re = PW'(ai) * PW'(bi) + PW'(aq) * PW'(bq);
  wire signed [PW-1:0] p_im = PW'(aq) * PW'(bi) - PW'(ai) * PW'(bq);

  wire signed [MW-1:0] sq_re = MW'(acc_re) * MW'(acc_re);
  wire signed [MW-1:0] sq_im = MW'(acc_im) * MW'(acc_im);
  wire [MW-1:0] mag_now = $unsigned(sq_re) + $unsigned(sq_im);

  wire is_edge = (bidx == '0) || (bidx == LW'(L - 1));
  wire [LW-1:0] im1 = (bidx == '0) ? bidx : bidx - LW'(1);
  wire [LW-1:0] ip1 = (bidx == LW'(L - 1)) ? bidx : bidx + LW'(1);
  wire [MW-1:0] c_v  = mag_m[bidx];
  wire [MW-1:0] m1_v = mag_m[im1];
  wire [MW-1:0] p1_v = mag_m[ip1];
  wire [DW-1:0] dsum = DW'({c_v, 1'b0}) - DW'(m1_v) - DW'(p1_v);
  wire [MW-1:0] absn = (m1_v >= p1_v) ? m1_v - p1_v : p1_v - m1_v;
  wire [RW-1:0] trial = den_r << qb;
  wire [6:0] qc = neg ? ((q > 7'd32) ? 7'd32 : q) : ((q > 7'd31) ? 7'd31 : q);

  always_ff @(posedge clk) begin
    if (ref_take) begin
      rim[rcnt[NAW-1:0]] <= ref_i;
      rqm[rcnt[NAW-1:0]] <= ref_q;
    end
    if (fb_take) begin
      fim[fcnt[FAW-1:0]] <= fb_i;
      fqm[fcnt[FAW-1:0]] <= fb_q;
    end
    if (st == S_MAG) mag_m[k] <= mag_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rcnt <= '0; fcnt <= '0; n <= '0; k <= '0; bidx <= '0;
      acc_re <= '0; acc_im <= '0; best <= '0;
      rem <= '0; den_r <= '0; qb <= '0; q <= '0; neg <= 1'b0; eflag <= 1'b0;
      lag_out <= '0; frac_out <= '0; edge_out <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rcnt <= '0;
          fcnt <= '0;
          st <= S_CAP;
        end
        S_CAP: begin
          if (ref_take) rcnt <= rcnt + NCW'(1);
          if (fb_take) fcnt <= fcnt + FCW'(1);
          if (cap_full) begin
            st <= S_MAC;
            k <= '0; n <= '0; bidx <= '0; best <= '0;
            acc_re <= '0; acc_im <= '0;
          end
        end
        S_MAC: begin
          acc_re <= acc_re + AW'(p_re);
          acc_im <= acc_im + AW'(p_im);
          if (n == NAW'(N - 1)) begin
            n <= '0;
            st <= S_MAG;
          end else n <= n + NAW'(1);
        end
        S_MAG: begin
          if (k == '0 || mag_now > best) begin
            best <= mag_now;
            bidx <= k;
          end
          acc_re <= '0;
          acc_im <= '0;
          if (k == LW'(L - 1)) st <= S_PICK;
          else begin
            k <= k + LW'(1);
            st <= S_MAC;
          end
        end
        S_PICK: begin
          q <= '0;
          qb <= 3'd6;
          eflag <= is_edge;
          neg <= 1'b0;
          if (is_edge || dsum == '0) st <= S_FIN;
          else begin
            rem <= RW'(absn) << 6;
            den_r <= RW'(dsum) << 1;
            neg <= m1_v > p1_v;
            st <= S_DIV;
          end
        end
        S_DIV: begin
          if (rem >= trial) begin
            rem <= rem - trial;
            q[qb] <= 1'b1;
          end
          if (qb == 3'd0) st <= S_FIN;
          else qb <= qb - 3'd1;
        end
        S_FIN: begin
          lag_out <= bidx;
          frac_out <= neg ? -$signed(qc) : $signed(qc);
          edge_out <= eflag;
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_cap_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= NCW'(N) && fcnt <= FCW'(NF));
  p_peak_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PICK |-> (m1_v <= c_v && p1_v <= c_v));
  p_tie_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PICK && bidx != '0) |-> m1_v < c_v);
  p_frac_clip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (frac_out >= -7'sd32 && frac_out <= 7'sd31));
  p_edge_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && edge_out) |-> (frac_out == 0 && (lag_out == '0 || lag_out == LW'(L - 1))));
  p_inner_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lag_out != '0 && lag_out != LW'(L - 1)) |-> !edge_out);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (done || $stable({lag_out, frac_out, edge_out})));
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && st != S_CAP && start) |=> st != S_CAP);
endmodule

// File: tb/xcorr_delay_est_tb_top.sv
module xcorr_delay_est_tb_top;
  localparam int W = 8;
  localparam int N = 32;
  localparam int L = 8;
  localparam int NF = N + L - 1;
  localparam int LW = $clog2(L);
  localparam int CLK_PERIOD = 10;
  localparam int LO = -(1 << (W - 1));
  localparam int HI = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ref_valid = 1'b0, fb_valid = 1'b0;
  logic signed [W-1:0] ref_i = '0, ref_q = '0, fb_i = '0, fb_q = '0;
  logic [LW-1:0] lag_out;
  logic signed [6:0] frac_out;
  logic edge_out, done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xcorr_delay_est #(.W(W), .N(N), .L(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ref_valid(ref_valid), .ref_i(ref_i), .ref_q(ref_q),
    .fb_valid(fb_valid), .fb_i(fb_i), .fb_q(fb_q),
    .lag_out(lag_out), .frac_out(frac_out), .edge_out(edge_out), .done(done));

  int total = 0, fails = 0;
  int rI[N], rQ[N], fI[NF], fQ[NF];
  int exp_lag, exp_frac, exp_edge;

  task automatic chk(bit ok, string tag, longint act, longint expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int rnd(int a);
    return int'($urandom_range(2 * a, 0)) - a;
  endfunction

  function automatic int clampw(int v);
    return (v > HI) ? HI : ((v < LO) ? LO : v);
  endfunction

  task automatic calc_expect();
    longint mg[L];
    longint re, im, c, m, p, num, den, qv;
    exp_lag = 0;
    for (int k = 0; k < L; k++) begin
      re = 0; im = 0;
      for (int n = 0; n < N; n++) begin
        re += longint'(fI[n+k] * rI[n] + fQ[n+k] * rQ[n]);
        im += longint'(fQ[n+k] * rI[n] - fI[n+k] * rQ[n]);
      end
      mg[k] = re * re + im * im;
      if (mg[k] > mg[exp_lag]) exp_lag = k;
    end
    exp_edge = (exp_lag == 0 || exp_lag == L - 1) ? 1 : 0;
    exp_frac = 0;
    if (!exp_edge) begin
      c = mg[exp_lag]; m = mg[exp_lag-1]; p = mg[exp_lag+1];
      num = m - p;
      den = 2 * (2 * c - m - p);
      if (den != 0) begin
        qv = ((num < 0 ? -num : num) * 64) / den;
        if (num > 0) exp_frac = (qv > 32) ? -32 : -int'(qv);
        else exp_frac = (qv > 31) ? 31 : int'(qv);
      end
    end
  endtask

  task automatic gen_shift(int d, int amp, int nz);
    for (int n = 0; n < N; n++) begin
      rI[n] = clampw(rnd(amp)); rQ[n] = clampw(rnd(amp));
    end
    for (int m = 0; m < NF; m++) begin
      if (m >= d && m - d < N) begin
        fI[m] = clampw(rI[m-d] + rnd(nz)); fQ[m] = clampw(rQ[m-d] + rnd(nz));
      end else begin
        fI[m] = clampw(rnd(amp)); fQ[m] = clampw(rnd(amp));
      end
    end
  endtask

  task automatic run_case(string lag_tag, bit pre_junk, bit busy_start);
    int ri, fi, cnt, lat;
    bit rv, fv, extra;
    logic [LW-1:0] l0;
    logic signed [6:0] f0;
    calc_expect();
    if (pre_junk) begin
      for (int j = 0; j < 8; j++) begin
        ref_valid = 1'b1; fb_valid = 1'b1;
        ref_i = W'($urandom); ref_q = W'($urandom);
        fb_i = W'($urandom); fb_q = W'($urandom);
        @(negedge clk);
      end
    end
    ref_valid = 1'b0; fb_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ri = 0; fi = 0;
    while (ri < N || fi < NF) begin
      rv = ($urandom % 4) != 0;
      fv = ($urandom % 4) != 0;
      ref_valid = rv; fb_valid = fv;
      ref_i = (ri < N) ? W'(rI[ri]) : W'($urandom);
      ref_q = (ri < N) ? W'(rQ[ri]) : W'($urandom);
      fb_i = (fi < NF) ? W'(fI[fi]) : W'($urandom);
      fb_q = (fi < NF) ? W'(fQ[fi]) : W'($urandom);
      @(negedge clk);
      if (rv && ri < N) ri++;
      if (fv && fi < NF) fi++;
    end
    ref_valid = 1'b0; fb_valid = 1'b0;
    cnt = 0;
    while (done !== 1'b1 && cnt < 4000) begin
      start = busy_start && (cnt == 20);
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    lat = exp_edge ? L * (N + 1) + 3 : L * (N + 1) + 10;
    chk(cnt == lat, "R7 latency", cnt, lat);
    chk(lag_out == LW'(exp_lag), lag_tag, lag_out, exp_lag);
    chk(frac_out == 7'(exp_frac), "R5 frac", frac_out, exp_frac);
    chk(edge_out == exp_edge[0], "R6 edge", edge_out, exp_edge);
    l0 = lag_out; f0 = frac_out;
    @(negedge clk);
    chk(done == 1'b0 && lag_out == l0 && frac_out == f0, "R7 pulse/hold", done, 0);
    if (busy_start) begin
      extra = 1'b0;
      for (int j = 0; j < 2 * L * (N + 1); j++) begin
        if (done) extra = 1'b1;
        @(negedge clk);
      end
      chk(!extra, "R8 busy start", extra, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(done == 0 && lag_out == 0, "R1 reset done/lag", {done, lag_out}, 0);
    chk(frac_out == 0 && edge_out == 0, "R1 reset frac/edge", {frac_out, edge_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && lag_out == 0 && frac_out == 0 && edge_out == 0, "R1 after release", done, 0);

    gen_shift(3, 120, 2);  run_case("R3 lag", 0, 0);
    gen_shift(0, 120, 2);  run_case("R6 lag at 0", 0, 0);
    gen_shift(L - 1, 120, 2); run_case("R6 lag at L-1", 0, 0);

    for (int n = 0; n < N; n++) begin rI[n] = 0; rQ[n] = 0; end
    for (int m = 0; m < NF; m++) begin fI[m] = 0; fQ[m] = 0; end
    rI[0] = 50; fI[2] = 60; fI[3] = 60;
    run_case("R4 tie interior", 0, 0);
    chk(exp_frac == 31, "R5 clip model", exp_frac, 31);

    for (int n = 0; n < N; n++) begin rI[n] = 100; rQ[n] = -30; end
    for (int m = 0; m < NF; m++) begin fI[m] = 100; fQ[m] = -30; end
    run_case("R4 flat tie", 0, 0);

    for (int n = 0; n < N; n++) begin
      rI[n] = ($urandom % 2) ? HI : LO; rQ[n] = ($urandom % 2) ? HI : LO;
    end
    for (int m = 0; m < NF; m++) begin
      fI[m] = (m >= 4 && m - 4 < N) ? rI[m-4] : LO;
      fQ[m] = (m >= 4 && m - 4 < N) ? rQ[m-4] : LO;
    end
    run_case("R9 full scale", 0, 0);
    for (int n = 0; n < N; n++) begin rI[n] = LO; rQ[n] = LO; end
    for (int m = 0; m < NF; m++) begin fI[m] = LO; fQ[m] = LO; end
    run_case("R9 all minimum", 0, 0);

    gen_shift(5, 100, 3); run_case("R2 junk before start", 1, 0);
    gen_shift(2, 100, 3); run_case("R8 lag", 0, 1);

    gen_shift(2, 100, 0);
    for (int m = 0; m < NF; m++) begin
      if (m >= 3 && m - 3 < N) begin
        fI[m] = (rI[m-2 < N ? m-2 : 0] + rI[m-3]) / 2;
        fQ[m] = (rQ[m-2 < N ? m-2 : 0] + rQ[m-3]) / 2;
      end
    end
    run_case("R5 half-sample lag", 0, 0);

    for (int t = 0; t < 16; t++) begin
      gen_shift(int'($urandom % L), 20 + int'($urandom % 100), int'($urandom % 40));
      run_case("R3 random lag", t % 5 == 0, 0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule